// File: doc/BRIEF.md
# Multi-mode 8-bit Shift Register

This block converts between a parallel byte and a serial bit stream. A 3-bit mode input selects the direction (receive or transmit) and where the shift clock comes from: a one-cycle zero pulse from a companion down-counter, the system clock itself, or an external clock line. When the block makes the shift clock itself, it drives the clock line with eight low-then-high periods per byte. Data changes after each falling edge of that line and is sampled on each rising edge. When the clock comes from outside, the block releases the line and follows its edges.

Software reaches the block through one data register. Any read or write strobe clears the completion flag, zeroes the bit counter and starts a fresh 8-bit transfer. A write also loads the byte. After the eighth bit the flag rises and the transfer stops. The exception is the free-running transmit mode, which rotates the byte out forever at the counter-pulse rate and never raises the flag.

Top module: `serial_shifter`

## Requirements
- R1: After reset the data register reads 0x00, the flag is low, the driven clock level is high and the serial output is high.
- R2: In mode 000 nothing shifts. The register keeps its value, the flag stays low and the clock line stays high, whatever happens on the counter-pulse, clock-line and data inputs.
- R3: `rdata_o` always shows the register. A write strobe loads `wdata_i`. A read or write strobe clears the flag and restarts a full 8-bit transfer from bit zero, discarding any partly done byte.
- R4: In receive modes (mode bit 2 = 0), `sdata_i` is sampled only on a rising shift-clock edge. The new bit enters bit 0 and older bits move toward bit 7, so the first bit received ends in bit 7.
- R5: In transmit modes (mode bit 2 = 1), `sdata_o` takes bit 7 of the register on each falling shift-clock edge. Bit 7 re-enters at bit 0 on the rising edge, so the byte leaves most significant bit first and the register again holds the original byte after eight bits. `sdata_i` is ignored.
- R6: Modes 010 and 110 use the system clock. The first cycle after the access drives the clock line low and the next drives it high, so one bit takes two cycles and the flag becomes visible exactly 16 cycles after the access edge.
- R7: Modes 001, 101 and 100 move one half-period per `t2_zero_i` pulse, whatever the spacing between pulses. Modes 001 and 101 set the flag on the 16th pulse.
- R8: Modes 011 and 111 release the clock line (`sclk_oe_o` = 0). They shift on a rising edge of `sclk_i` and update the transmitted bit on a falling edge of `sclk_i`.
- R9: In every mode other than 000 and 100, the eighth rising edge sets the flag and ends the transfer, and the driven clock level returns high.
- R10: Mode 100 rotates the byte continuously, with the same bit sequence on every pass, and never sets the flag.
- R11: `sclk_oe_o` is high exactly in modes 001, 010, 100, 101 and 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Mode: bit 2 selects direction, bits 1:0 select the clock source |
| wr_en_i | input | 1 | Write strobe for the data register |
| rd_en_i | input | 1 | Read strobe for the data register |
| wdata_i | input | 8 | Byte to load on a write |
| rdata_o | output | 8 | Current register contents |
| t2_zero_i | input | 1 | One-cycle zero pulse from the companion counter |
| sclk_i | input | 1 | Level seen on the clock line |
| sclk_o | output | 1 | Level driven on the clock line |
| sclk_oe_o | output | 1 | Drive enable for the clock line |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |
| done_o | output | 1 | Transfer-complete flag |

## Verification
Random bytes travel in both directions under each of the three clock sources. In receive mode the bench changes the data input on falling half-steps as well as rising ones, which separates sampling on the rising edge from sampling on any clock event. Counter pulses and external clock edges arrive with random gaps. This shows that progress follows events and not elapsed cycles, while the system-clock runs pin the flag to exactly the sixteenth cycle. Directed cases cover the disabled mode under noisy inputs, a restart in the middle of a byte (which must leave a predictable rotation), the clear-on-read of the flag, and two full passes in the free-running mode.

// File: rtl/shr_pkg.sv
// Shared mode encoding and decode helpers for the serial shifter.
// Assumes the 3-bit mode layout: bit 2 direction, bits 1:0 clock source.
package shr_pkg;

    typedef enum logic [2:0] {
        SHM_OFF      = 3'b000,
        SHM_IN_T2    = 3'b001,
        SHM_IN_SYS   = 3'b010,
        SHM_IN_EXT   = 3'b011,
        SHM_OUT_FREE = 3'b100,
        SHM_OUT_T2   = 3'b101,
        SHM_OUT_SYS  = 3'b110,
        SHM_OUT_EXT  = 3'b111
    } shr_mode_e;

    // Transmit direction
    function automatic logic m_is_out(input logic [2:0] m);
        return m[2];
    endfunction

    // Clock taken from the external line
    function automatic logic m_is_ext(input logic [2:0] m);
        return m[1:0] == 2'b11;
    endfunction

    // Clock derived from the counter zero pulse
    function automatic logic m_uses_t2(input logic [2:0] m);
        return (m[1:0] == 2'b01) || (m == SHM_OUT_FREE);
    endfunction

    // Clock derived from every system clock cycle
    function automatic logic m_uses_sys(input logic [2:0] m);
        return m[1:0] == 2'b10;
    endfunction

    // Block generates and drives the shift clock
    function automatic logic m_is_internal(input logic [2:0] m);
        return m_uses_t2(m) || m_uses_sys(m);
    endfunction

    // Endless recirculation without completion flag
    function automatic logic m_is_free(input logic [2:0] m);
        return m == SHM_OUT_FREE;
    endfunction

endpackage

// File: rtl/shr_edge_src.sv
// Produces one-cycle falling and rising shift events from the selected source.
// Internal sources toggle a phase flop that is also the driven clock level;
// the external source is edge-detected with one flop. Assumes sclk_i is
// synchronous to clk and holds each level for at least one cycle.
module shr_edge_src
    import shr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       active_i,
    input  logic       access_i,
    input  logic       t2_zero_i,
    input  logic       sclk_i,
    output logic       fall_ev_o,
    output logic       rise_ev_o,
    output logic       sclk_o
);

    logic phase_hi_q;
    logic ext_q;
    logic tick_int;
    logic ext_fall;
    logic ext_rise;

    // Internal tick: each one advances the driven clock by half a period
    always_comb begin
        tick_int = 1'b0;
        if (active_i && !access_i && m_is_internal(mode_i)) begin
            tick_int = m_uses_sys(mode_i) || (m_uses_t2(mode_i) && t2_zero_i);
        end
    end

    // Phase flop: idles high, flips on every internal tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi_q <= 1'b1;
        end else if (access_i || !active_i) begin
            phase_hi_q <= 1'b1;
        end else if (tick_int) begin
            phase_hi_q <= ~phase_hi_q;
        end
    end

    // Previous level of the external clock line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b1;
        end else begin
            ext_q <= sclk_i;
        end
    end

    // External edge detect, gated by mode and transfer state
    always_comb begin
        ext_fall = active_i && !access_i && m_is_ext(mode_i) && ext_q && !sclk_i;
        ext_rise = active_i && !access_i && m_is_ext(mode_i) && !ext_q && sclk_i;
    end

    // Merge both sources into a single pair of events
    always_comb begin
        fall_ev_o = (tick_int && phase_hi_q) || ext_fall;
        rise_ev_o = (tick_int && !phase_hi_q) || ext_rise;
        sclk_o    = phase_hi_q;
    end

endmodule

// File: rtl/shr_ctrl.sv
// Bit counter, transfer-active state and completion flag.
// Assumes mode_i is held stable while a transfer is active.
module shr_ctrl
    import shr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       access_i,
    input  logic       rise_ev_i,
    output logic       active_o,
    output logic       done_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             done_q;

    // Count bits, end the byte, raise the flag unless free-running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else if (access_i) begin
            cnt_q    <= '0;
            active_q <= (mode_i != SHM_OFF);
            done_q   <= 1'b0;
        end else if (rise_ev_i) begin
            if (cnt_q == LAST_BIT) begin
                cnt_q <= '0;
                if (!m_is_free(mode_i)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign done_o   = done_q;

    // R3
    access_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_i |=> (!done_q && cnt_q == '0));

    // R9
    flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(rise_ev_i));

    // R10
    free_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !m_is_free($past(mode_i)));

    // R9
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !active_q);

endmodule

// File: rtl/shr_datapath.sv
// The shift register proper and the registered serial output bit.
// Assumes events are already gated against an access in the same cycle.
module shr_datapath
    import shr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fall_ev_i,
    input  logic              rise_ev_i,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] shreg_o,
    output logic              sdata_o
);

    logic [DATA_W-1:0] shreg_q;
    logic              sd_q;

    // Parallel load or one-place shift toward the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (wr_i) begin
            shreg_q <= wdata_i;
        end else if (rise_ev_i) begin
            if (m_is_out(mode_i)) begin
                shreg_q <= {shreg_q[DATA_W-2:0], shreg_q[DATA_W-1]};
            end else begin
                shreg_q <= {shreg_q[DATA_W-2:0], sdata_i};
            end
        end
    end

    // Present the top bit after each falling edge when transmitting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b1;
        end else if (fall_ev_i && m_is_out(mode_i)) begin
            sd_q <= shreg_q[DATA_W-1];
        end
    end

    assign shreg_o = shreg_q;
    assign sdata_o = sd_q;

    // R2
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SHM_OFF && !wr_i) |=> $stable(shreg_q));

    // R5
    rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_is_out(mode_i) && !wr_i) |=> ($countones(shreg_q) == $countones($past(shreg_q))));

endmodule

// File: rtl/serial_shifter.sv
// Top of the multi-mode shift register: wires the event source, the
// controller and the datapath. Any read or write strobe restarts a byte.
// Assumes mode_i changes only while no transfer is running.
module serial_shifter
    import shr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              t2_zero_i,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    input  logic              sdata_i,
    output logic              sdata_o,
    output logic              done_o
);

    logic access;
    logic active;
    logic fall_ev;
    logic rise_ev;

    // Any register strobe counts as an access
    assign access    = wr_en_i || rd_en_i;
    // Drive the clock line only when generating the clock
    assign sclk_oe_o = m_is_internal(mode_i);

    shr_edge_src i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .active_i  (active),
        .access_i  (access),
        .t2_zero_i (t2_zero_i),
        .sclk_i    (sclk_i),
        .fall_ev_o (fall_ev),
        .rise_ev_o (rise_ev),
        .sclk_o    (sclk_o)
    );

    shr_ctrl #(.DATA_W(DATA_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .access_i  (access),
        .rise_ev_i (rise_ev),
        .active_o  (active),
        .done_o    (done_o)
    );

    shr_datapath #(.DATA_W(DATA_W)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .wr_i      (wr_en_i),
        .wdata_i   (wdata_i),
        .fall_ev_i (fall_ev),
        .rise_ev_i (rise_ev),
        .sdata_i   (sdata_i),
        .shreg_o   (rdata_o),
        .sdata_o   (sdata_o)
    );

    // R9
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sclk_o);

    // R6
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_ev, rise_ev}));

endmodule

// File: tb/test_serial_shifter.sv
module test_serial_shifter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       t2_zero = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sclk_out;
    logic       sclk_oe;
    logic       sdata_in = 1'b0;
    logic       sdata_out;
    logic       done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_shifter i_serial_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .t2_zero_i (t2_zero),
        .sclk_i    (sclk_in),
        .sclk_o    (sclk_out),
        .sclk_oe_o (sclk_oe),
        .sdata_i   (sdata_in),
        .sdata_o   (sdata_out),
        .done_o    (done)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_oe(input logic [2:0] m);
        return (m == 3'b001) || (m == 3'b010) || (m == 3'b100) || (m == 3'b101) || (m == 3'b110);
    endfunction

    function automatic logic [7:0] exp_in(input logic [7:0] bits);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[7-k] = bits[k];
        return r;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        logic [7:0] r = v;
        for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
        return r;
    endfunction

    task automatic do_write(input logic [7:0] b);
        wdata = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // One half-period of shift clock from whichever source the mode uses
    task automatic tick(input logic [2:0] m, input bit rising);
        if (m[1:0] == 2'b10) begin
            @(negedge clk);
        end else if (m[1:0] == 2'b11) begin
            sclk_in = rising;
            @(negedge clk);
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end else begin
            t2_zero = 1'b1;
            @(negedge clk);
            t2_zero = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [2:0] m, input logic [7:0] w, input logic [7:0] inb, input int reps);
        logic [7:0] got = 8'h00;
        mode = m;
        do_write(w);
        if (m[1:0] == 2'b11) chk("R8", "clock released", sclk_oe, 0);
        else chk("R11", "clock driven", sclk_oe, 1);
        for (int h = 0; h < 16 * reps; h++) begin
            automatic bit rising = h[0];
            automatic int bi = (h % 16) / 2;
            sdata_in = rising ? inb[bi] : 1'($urandom);
            tick(m, rising);
            if (m[1:0] != 2'b11) chk(m[1] ? "R6" : "R7", "clock level", sclk_out, rising);
            if (!rising && m[2]) got[7 - bi] = sdata_out;
            if (h == 16 * reps - 2) chk("R9", "flag before last edge", done, 0);
        end
        if (m == 3'b100) begin
            chk("R10", "free run no flag", done, 0);
            chk("R10", "free run bits", got, w);
            chk("R10", "free run register", rdata, w);
        end else if (m[2]) begin
            chk("R5", "msb-first stream", got, w);
            chk("R5", "register restored", rdata, w);
            chk("R9", "flag set", done, 1);
            chk("R9", "clock idle", sclk_out, 1);
        end else begin
            chk("R4", "received byte", rdata, exp_in(inb));
            chk("R9", "flag set", done, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "register", rdata, 8'h00);
        chk("R1", "flag", done, 0);
        chk("R1", "clock level", sclk_out, 1);
        chk("R1", "serial out", sdata_out, 1);

        // R11 drive enable per mode
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            @(negedge clk);
            chk("R11", "drive enable", sclk_oe, exp_oe(3'(m)));
        end

        // R2 disabled mode with noisy inputs
        mode = 3'b000;
        do_write(8'hA5);
        for (int k = 0; k < 20; k++) begin
            t2_zero = k[0]; sclk_in = k[1]; sdata_in = k[2];
            @(negedge clk);
        end
        t2_zero = 1'b0; sclk_in = 1'b1;
        @(negedge clk);
        chk("R2", "register held", rdata, 8'hA5);
        chk("R2", "flag low", done, 0);
        chk("R2", "clock high", sclk_out, 1);

        // R3 restart mid-byte by a read, then exact 16-cycle timing (R6)
        mode = 3'b110;
        do_write(8'h3C);
        repeat (6) @(negedge clk);
        do_read();
        repeat (15) @(negedge clk);
        chk("R6", "flag one cycle early", done, 0);
        @(negedge clk);
        chk("R6", "flag at 16 cycles", done, 1);
        chk("R3", "restart rotation", rdata, rotl(8'h3C, 11));
        do_read();
        chk("R3", "read clears flag", done, 0);
        chk("R3", "read keeps data", rdata, rotl(8'h3C, 11));

        // Random transfers across sources and directions
        for (int n = 0; n < 14; n++) begin
            automatic logic [2:0] m;
            case ($urandom_range(0, 5))
                0: m = 3'b001; 1: m = 3'b010; 2: m = 3'b011;
                3: m = 3'b101; 4: m = 3'b110; default: m = 3'b111;
            endcase
            xfer(m, 8'($urandom), 8'($urandom), 1);
        end
        // Directed corner bytes
        xfer(3'b110, 8'h80, 8'h00, 1);
        xfer(3'b010, 8'hFF, 8'h01, 1);
        xfer(3'b111, 8'h01, 8'h00, 1);
        // R10 two passes of free running
        xfer(3'b100, 8'hB4, 8'h00, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule